// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block turns one vector instruction into a stream of element operations. A start pulse captures the vector length, a per-operand "is vector" flag set and a predicate mask, then walks an element step from the resume point up to the last element. Each operand slot has its own element counter. Slot 0 is the destination and slots 1 to 3 are sources. A counter moves forward only when its operand is a vector, so a scalar operand stays at index 0.

Each counter is sent out on its own remap request lane. The remapped offsets that come back on the matching response lanes are presented together with the step on a valid/ready element interface. Steps whose predicate bit is clear issue nothing.

The current step is visible at all times as a saved-state value. An interrupt parks the loop with that step held. Software then restarts the instruction with the saved step as the resume point, and the block rebuilds every operand counter before issuing again. If any remap lane flags a register-file overrun, the sequence stops with an illegal-instruction pulse.

Top module: `vec_elem_seq`

## Requirements
- R1: After a start with resume step 0, elements are issued in increasing step order. The step advances only on a cycle where `el_valid_o` and `el_ready_i` are both high, and while ready is low the step and `srcstep_o` hold.
- R2: `srcstep_o` shows the current element step in every cycle. It returns to 0 once an instruction completes normally.
- R3: A step whose bit in `mask_i` (bit n for step n) is clear issues nothing. It is passed in a single cycle without waiting for ready. With every bit clear, `done_o` is seen on the cycle vl+2 after the start is sampled.
- R4: In `vec_i`, bit 0 marks the destination as a vector and bits 1 to 3 mark sources 1 to 3. While running, the index of a vector operand equals the current step, and the index of a scalar operand is 0.
- R5: Slot k of `el_off_o` (bits k*IDX_W upward) carries the response of remap lane k for the index sent on request lane k. The lanes are independent of one another.
- R6: A scalar destination ends the loop after its first step, whether that step was issued or masked, with a `done_o` pulse.
- R7: `done_o` is a single-cycle pulse that follows the final step (vl-1). It never coincides with `illegal_o`.
- R8: If any bit of `rm_ovf_i` is set while running, no element issues, `illegal_o` pulses, busy drops, and `srcstep_o` keeps the faulting step.
- R9: `irq_i` while running parks the loop with no done and `srcstep_o` held. A new start with `resume_i` equal to that step carries on from it, after the operand indices are rebuilt.
- R10: A start with `resume_i` at or beyond vl finishes with `done_o` and issues no element.
- R11: With vl 16 and three vector operands, an operand whose remap lane is identity plus a base walks 16 consecutive offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin (or resume) an instruction |
| vl_i | input | $clog2(VL_MAX+1) | Vector length |
| vec_i | input | OPS | Per-slot vector flag, bit 0 destination |
| mask_i | input | VL_MAX | Predicate, bit n for step n |
| resume_i | input | $clog2(VL_MAX) | First step (0 for a fresh instruction) |
| irq_i | input | 1 | Interrupt: park the loop |
| rm_idx_o | output | OPS*IDX_W | Operand counters to the remap lanes |
| rm_off_i | input | OPS*IDX_W | Remapped offsets from the lanes |
| rm_ovf_i | input | OPS | Per-lane register-file overrun |
| el_valid_o | output | 1 | Element operation valid |
| el_ready_i | input | 1 | Element operation accepted |
| el_step_o | output | $clog2(VL_MAX) | Step of the element operation |
| el_off_o | output | OPS*IDX_W | Per-slot offsets of the element operation |
| srcstep_o | output | $clog2(VL_MAX) | Saved current step |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Illegal-instruction pulse |

## Verification
The assertions assume the following about the inputs:
- The remap lanes answer in the same cycle as the request.
- `start_i` is raised only while the block is idle.
- `vl_i` never exceeds VL_MAX.

The bench models the remap lanes combinationally as an identity or a 4x4 transpose plus a per-lane base. It pulses start only after done, illegal or a parked interrupt has been seen. Every vl it uses stays within range, and the overrun limit is changed only between instructions.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PREP = 2'd1,
        SQ_RUN  = 2'd2
    } sq_state_e;

    // Outcome of one run cycle, decided combinationally
    typedef struct packed {
        logic pause;
        logic fault;
        logic finish;
        logic step_on;
    } sq_decision_t;

    function automatic sq_decision_t decide(
        input logic run,
        input logic irq,
        input logic ovf,
        input logic active,
        input logic ready,
        input logic last,
        input logic dst_vec
    );
        sq_decision_t d;
        logic moving;
        moving    = run & ~irq & ~ovf & (~active | ready);
        d.pause   = run & irq;
        d.fault   = run & ~irq & ovf;
        d.finish  = moving & (last | ~dst_vec);
        d.step_on = moving & ~(last | ~dst_vec);
        return d;
    endfunction

endpackage

// File: rtl/vseq_opnd_ctr.sv
module vseq_opnd_ctr #(
    parameter int IDX_W  = 8,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              vec_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [IDX_W-1:0]  idx_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o <= '0;
        end else if (load_i) begin
            idx_o <= vec_i ? IDX_W'(step_i) : '0;
        end else if (adv_i && vec_i) begin
            idx_o <= idx_o + IDX_W'(1);
        end
    end
endmodule

// File: rtl/vseq_step_ctrl.sv
module vseq_step_ctrl
    import vseq_pkg::*;
#(
    parameter int VL_MAX = 64,
    parameter int OPS    = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [$clog2(VL_MAX+1)-1:0]  vl_i,
    input  logic [OPS-1:0]               vec_i,
    input  logic [VL_MAX-1:0]            mask_i,
    input  logic [$clog2(VL_MAX)-1:0]    resume_i,
    input  logic                         irq_i,
    input  logic                         ovf_i,
    input  logic                         ready_i,
    output logic [$clog2(VL_MAX)-1:0]    step_o,
    output logic [OPS-1:0]               vec_o,
    output logic                         load_o,
    output logic                         adv_o,
    output logic                         valid_o,
    output logic                         run_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         illegal_o
);
    localparam int STEP_W = $clog2(VL_MAX);
    localparam int VL_W   = $clog2(VL_MAX + 1);

    sq_state_e          state_q;
    logic [STEP_W-1:0]  step_q;
    logic [VL_W-1:0]    vl_q;
    logic [OPS-1:0]     vec_q;
    logic [VL_MAX-1:0]  mask_q;
    logic               done_q;
    logic               ill_q;
    logic               active;
    logic               last;
    logic               empty;
    sq_decision_t       dec;

    assign run_o  = (state_q == SQ_RUN);
    assign active = mask_q[step_q];
    assign last   = (VL_W'(step_q) + VL_W'(1)) == vl_q;
    assign empty  = VL_W'(step_q) >= vl_q;
    assign dec    = decide(run_o, irq_i, ovf_i, active, ready_i, last, vec_q[0]);

    assign valid_o   = run_o & ~irq_i & ~ovf_i & active;
    assign load_o    = (state_q == SQ_PREP);
    assign adv_o     = dec.step_on;
    assign busy_o    = (state_q != SQ_IDLE);
    assign step_o    = step_q;
    assign vec_o     = vec_q;
    assign done_o    = done_q;
    assign illegal_o = ill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            vl_q    <= '0;
            vec_q   <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        vl_q    <= vl_i;
                        vec_q   <= vec_i;
                        mask_q  <= mask_i;
                        step_q  <= resume_i;
                        state_q <= SQ_PREP;
                    end
                end
                SQ_PREP: begin
                    if (empty) begin
                        done_q  <= 1'b1;
                        step_q  <= '0;
                        state_q <= SQ_IDLE;
                    end else begin
                        state_q <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (dec.pause) begin
                        state_q <= SQ_IDLE;
                    end else if (dec.fault) begin
                        ill_q   <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else if (dec.finish) begin
                        done_q  <= 1'b1;
                        step_q  <= '0;
                        state_q <= SQ_IDLE;
                    end else if (dec.step_on) begin
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
    parameter int VL_MAX = 64,
    parameter int OPS    = 4,
    parameter int IDX_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [$clog2(VL_MAX+1)-1:0]  vl_i,
    input  logic [OPS-1:0]               vec_i,
    input  logic [VL_MAX-1:0]            mask_i,
    input  logic [$clog2(VL_MAX)-1:0]    resume_i,
    input  logic                         irq_i,
    output logic [OPS*IDX_W-1:0]         rm_idx_o,
    input  logic [OPS*IDX_W-1:0]         rm_off_i,
    input  logic [OPS-1:0]               rm_ovf_i,
    output logic                         el_valid_o,
    input  logic                         el_ready_i,
    output logic [$clog2(VL_MAX)-1:0]    el_step_o,
    output logic [OPS*IDX_W-1:0]         el_off_o,
    output logic [$clog2(VL_MAX)-1:0]    srcstep_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         illegal_o
);
    localparam int STEP_W = $clog2(VL_MAX);

    logic [STEP_W-1:0] seq_step;
    logic [OPS-1:0]    seq_vec;
    logic              seq_load;
    logic              seq_adv;
    logic              seq_run;

    vseq_step_ctrl #(.VL_MAX(VL_MAX), .OPS(OPS)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .vl_i      (vl_i),
        .vec_i     (vec_i),
        .mask_i    (mask_i),
        .resume_i  (resume_i),
        .irq_i     (irq_i),
        .ovf_i     (|rm_ovf_i),
        .ready_i   (el_ready_i),
        .step_o    (seq_step),
        .vec_o     (seq_vec),
        .load_o    (seq_load),
        .adv_o     (seq_adv),
        .valid_o   (el_valid_o),
        .run_o     (seq_run),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .illegal_o (illegal_o)
    );

    for (genvar k = 0; k < OPS; k++) begin : g_lane
        vseq_opnd_ctr #(.IDX_W(IDX_W), .STEP_W(STEP_W)) ctr_i (
            .clk    (clk),
            .rst    (rst),
            .load_i (seq_load),
            .adv_i  (seq_adv),
            .vec_i  (seq_vec[k]),
            .step_i (seq_step),
            .idx_o  (rm_idx_o[k*IDX_W +: IDX_W])
        );
    end

    assign el_off_o  = rm_off_i;
    assign el_step_o = seq_step;
    assign srcstep_o = seq_step;
endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
    parameter int VL_MAX = 64,
    parameter int OPS    = 4,
    parameter int IDX_W  = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      run,
    input logic [OPS-1:0]            vec_q,
    input logic                      irq_i,
    input logic [OPS-1:0]            rm_ovf_i,
    input logic [OPS*IDX_W-1:0]      rm_idx_o,
    input logic                      el_valid_o,
    input logic                      el_ready_i,
    input logic [$clog2(VL_MAX)-1:0] srcstep_o,
    input logic                      busy_o,
    input logic                      done_o,
    input logic                      illegal_o
);
    // R1: nothing is offered outside the run phase
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |-> !el_valid_o);

    // R1: a stalled element keeps its step
    a_r1_stall_hold: assert property (@(posedge clk) disable iff (rst)
        el_valid_o && !el_ready_i |=> $stable(srcstep_o));

    // R6: accepted element with scalar destination ends the loop
    a_r6_scalar_dst_stop: assert property (@(posedge clk) disable iff (rst)
        el_valid_o && el_ready_i && !vec_q[0] |=> done_o && !busy_o);

    // R7: the two exit pulses are exclusive
    a_r7_one_exit: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, illegal_o}));

    // R8: an overrun ends the run with an illegal pulse
    a_r8_overrun_abort: assert property (@(posedge clk) disable iff (rst)
        run && !irq_i && (|rm_ovf_i) |=> illegal_o && !busy_o);

    for (genvar k = 0; k < OPS; k++) begin : g_idx
        // R4: operand index tracks the step or stays at zero
        a_r4_lane_index: assert property (@(posedge clk) disable iff (rst)
            run |-> rm_idx_o[k*IDX_W +: IDX_W] ==
                    (vec_q[k] ? IDX_W'(srcstep_o) : IDX_W'(0)));
    end
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.VL_MAX(VL_MAX), .OPS(OPS), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .run        (seq_run),
    .vec_q      (seq_vec),
    .irq_i      (irq_i),
    .rm_ovf_i   (rm_ovf_i),
    .rm_idx_o   (rm_idx_o),
    .el_valid_o (el_valid_o),
    .el_ready_i (el_ready_i),
    .srcstep_o  (srcstep_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o)
);

// File: tb/vec_elem_seq_tb_top.sv
module vec_elem_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VL_MAX = 64;
    localparam int OPS    = 4;
    localparam int IDX_W  = 8;
    localparam int STEP_W = 6;
    localparam int VL_W   = 7;

    typedef struct packed {
        logic [STEP_W-1:0]    step;
        logic [OPS*IDX_W-1:0] off;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [VL_W-1:0] vl_i = '0;
    logic [OPS-1:0] vec_i = '0;
    logic [VL_MAX-1:0] mask_i = '0;
    logic [STEP_W-1:0] resume_i = '0;
    logic irq_i = 1'b0;
    logic [OPS*IDX_W-1:0] rm_idx_o;
    logic [OPS*IDX_W-1:0] rm_off_i;
    logic [OPS-1:0] rm_ovf_i;
    logic el_valid_o;
    logic el_ready_i = 1'b1;
    logic [STEP_W-1:0] el_step_o;
    logic [OPS*IDX_W-1:0] el_off_o;
    logic [STEP_W-1:0] srcstep_o;
    logic busy_o, done_o, illegal_o;

    logic [IDX_W-1:0] base [OPS];
    logic [IDX_W-1:0] lim [OPS];
    item_t exp_q[$];
    int total = 0;
    int bad = 0;
    int acc_cnt = 0;
    int ready_mode = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_elem_seq #(.VL_MAX(VL_MAX), .OPS(OPS), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i), .vec_i(vec_i),
        .mask_i(mask_i), .resume_i(resume_i), .irq_i(irq_i),
        .rm_idx_o(rm_idx_o), .rm_off_i(rm_off_i), .rm_ovf_i(rm_ovf_i),
        .el_valid_o(el_valid_o), .el_ready_i(el_ready_i), .el_step_o(el_step_o),
        .el_off_o(el_off_o), .srcstep_o(srcstep_o), .busy_o(busy_o),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    // Remap lane model: lane 1 transposes a 4x4 tile, the others are identity; all add a base
    function automatic logic [IDX_W-1:0] remap_fn(int k, logic [IDX_W-1:0] idx, logic [IDX_W-1:0] b);
        if (k == 1) return {idx[7:4], idx[1:0], idx[3:2]} + b;
        return idx + b;
    endfunction

    always_comb begin
        for (int k = 0; k < OPS; k++) begin
            rm_off_i[k*IDX_W +: IDX_W] = remap_fn(k, rm_idx_o[k*IDX_W +: IDX_W], base[k]);
            rm_ovf_i[k] = rm_idx_o[k*IDX_W +: IDX_W] >= lim[k];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Ready pattern, changed just after the clock edge
    always @(posedge clk) begin
        #1;
        if (ready_mode == 0) el_ready_i = 1'b1;
        else if (ready_mode == 1) el_ready_i = ($urandom % 3) != 0;
        else el_ready_i = 1'b0;
    end

    // Monitor: pop and compare each accepted element
    always @(negedge clk) begin
        if (!rst && el_valid_o && el_ready_i) begin
            item_t e;
            acc_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected element step", el_step_o, -1);
            end else begin
                e = exp_q.pop_front();
                check(el_step_o == e.step, cur_req, "element step", el_step_o, e.step);
                check(el_off_o == e.off, cur_req, "element offsets", el_off_o, e.off);
            end
        end
    end

    // Driver: push expected items, then pulse start
    task automatic launch(input int vl, input logic [OPS-1:0] vec, input logic [VL_MAX-1:0] mask,
                          input int resume, input int stop_at, input bit push);
        if (push) begin
            for (int s = resume; s < vl; s++) begin
                if (stop_at >= 0 && s >= stop_at) break;
                if (mask[s]) begin
                    item_t it;
                    it.step = STEP_W'(s);
                    for (int k = 0; k < OPS; k++) begin
                        logic [IDX_W-1:0] idx;
                        idx = vec[k] ? IDX_W'(s) : '0;
                        it.off[k*IDX_W +: IDX_W] = remap_fn(k, idx, base[k]);
                    end
                    exp_q.push_back(it);
                end
                if (!vec[0]) break;
            end
        end
        @(posedge clk); #1;
        vl_i = VL_W'(vl); vec_i = vec; mask_i = mask; resume_i = STEP_W'(resume);
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_ill, output int n);
        got_done = 0; got_ill = 0; n = 0;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (done_o) begin got_done = 1; break; end
            if (illegal_o) begin got_ill = 1; break; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit gd, gi;
        int n, a0, parked;
        base[0] = 8'd100; base[1] = 8'd64; base[2] = 8'd16; base[3] = 8'd200;
        for (int k = 0; k < OPS; k++) lim[k] = 8'd255;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // reset state (R2, R7)
        check(!busy_o && !el_valid_o, "R1", "idle after reset", busy_o, 0);
        check(srcstep_o == 0, "R2", "srcstep after reset", srcstep_o, 0);
        check(!done_o && !illegal_o, "R7", "no exit pulse after reset", done_o, 0);

        // R11 / R5 / R4: vl 16, dest and two sources vector, source 3 scalar
        cur_req = "R11";
        launch(16, 4'b0111, {VL_MAX{1'b1}}, 0, -1, 1);
        wait_end(gd, gi, n);
        check(gd, "R7", "done after full run", gd, 1);
        check(exp_q.size() == 0, "R11", "all 16 elements seen", exp_q.size(), 0);
        check(srcstep_o == 0, "R2", "srcstep back to zero", srcstep_o, 0);

        // R3 / R1: sparse predicate with random ready stalls
        cur_req = "R3"; ready_mode = 1;
        launch(16, 4'b1011, 64'hA5C3, 0, -1, 1);
        wait_end(gd, gi, n);
        check(gd && exp_q.size() == 0, "R3", "masked run completes", exp_q.size(), 0);
        ready_mode = 0;

        // R3: all masked, one cycle per step
        a0 = acc_cnt;
        launch(4, 4'b1111, '0, 0, -1, 1);
        wait_end(gd, gi, n);
        check(gd && n == 6, "R3", "cycles to done with empty mask", n, 6);
        check(acc_cnt == a0, "R3", "no element issued", acc_cnt - a0, 0);

        // R1: stall holds step
        cur_req = "R1"; ready_mode = 2;
        launch(4, 4'b1111, {VL_MAX{1'b1}}, 0, -1, 1);
        repeat (5) @(negedge clk);
        check(el_valid_o && srcstep_o == 0, "R1", "stalled step", srcstep_o, 0);
        ready_mode = 0;
        wait_end(gd, gi, n);
        check(gd && exp_q.size() == 0, "R1", "stalled run completes", exp_q.size(), 0);

        // R6: scalar destination, first step issued
        cur_req = "R6"; a0 = acc_cnt;
        launch(8, 4'b0110, {VL_MAX{1'b1}}, 0, -1, 1);
        wait_end(gd, gi, n);
        check(gd && acc_cnt - a0 == 1, "R6", "single element then done", acc_cnt - a0, 1);
        // R6: scalar destination, first step masked
        a0 = acc_cnt;
        launch(8, 4'b0110, 64'hFE, 0, -1, 1);
        wait_end(gd, gi, n);
        check(gd && acc_cnt == a0, "R6", "masked first step ends loop", acc_cnt - a0, 0);

        // R9: interrupt then resume
        cur_req = "R9"; a0 = acc_cnt;
        launch(16, 4'b1111, {VL_MAX{1'b1}}, 0, -1, 1);
        while (acc_cnt < a0 + 3) @(negedge clk);
        @(posedge clk); #1 irq_i = 1'b1;
        @(posedge clk); #1 irq_i = 1'b0;
        @(negedge clk);
        parked = acc_cnt - a0;
        check(!busy_o && !done_o, "R9", "parked without done", busy_o, 0);
        check(srcstep_o == parked, "R9", "saved step", srcstep_o, parked);
        launch(16, 4'b1111, {VL_MAX{1'b1}}, int'(srcstep_o), -1, 0);
        wait_end(gd, gi, n);
        check(gd && exp_q.size() == 0, "R9", "resumed run completes", exp_q.size(), 0);
        check(acc_cnt - a0 == 16, "R9", "element count over both halves", acc_cnt - a0, 16);

        // R8: overrun on lane 2 at index 5
        cur_req = "R8"; lim[2] = 8'd5;
        launch(8, 4'b1111, {VL_MAX{1'b1}}, 0, 5, 1);
        wait_end(gd, gi, n);
        check(gi && !gd, "R8", "illegal pulse", gi, 1);
        check(srcstep_o == 5 && !busy_o, "R8", "faulting step kept", srcstep_o, 5);
        check(exp_q.size() == 0, "R8", "elements before fault", exp_q.size(), 0);
        lim[2] = 8'd255;

        // R10: resume past the end
        cur_req = "R10"; a0 = acc_cnt;
        launch(8, 4'b1111, {VL_MAX{1'b1}}, 8, -1, 1);
        wait_end(gd, gi, n);
        check(gd && acc_cnt == a0, "R10", "done without issue", acc_cnt - a0, 0);

        // R5 / R4: vl 1 boundary with scalar sources
        cur_req = "R5";
        launch(1, 4'b0001, {VL_MAX{1'b1}}, 0, -1, 1);
        wait_end(gd, gi, n);
        check(gd && exp_q.size() == 0, "R4", "single element run", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule